// File: doc/BRIEF.md
# Banked Working Register File

This block stores the working registers of a 4-bit datapath. There are four banks of eight 4-bit cells, so the block holds 32 cells in total. Together the cells fill data-memory addresses 00h to 1Fh, and bank `b` takes addresses `8*b` to `8*b+7`.

Three register ports reach the cells by name: a nibble port, a single-bit port and an 8-bit pair port. A named access goes to the bank picked by the bank-select value when the bank-enable flag is set, and to bank 0 when the flag is clear. A fourth port reaches the same cells by their plain data-memory address and ignores the bank controls.

All reads are combinational and show the stored contents. All writes take effect at the next rising clock edge.

Top module: `wreg_file`

## Requirements
- R1: After an active-low reset, every one of the 32 cells reads 0 through the memory port.
- R2: When `bank_en` is 0, named accesses use bank 0 whatever `bank_sel` holds. When it is 1, they use bank `bank_sel`, and cell `r` of bank `b` is memory address `8*b + r`.
- R3: Named registers sit at these offsets inside a bank: A=0, E=1, L=2, H=3, X=4, W=5, Z=6, Y=7. The nibble port reads and writes the register at offset `nib_sel`.
- R4: Pair codes are EA=0, HL=1, WX=2, YZ=3 and WL=4. The first-named register of a pair is `pair_rdata[7:4]`/`pair_wdata[7:4]` and the second is bits [3:0].
- R5: A pair write updates both of its nibbles at the same clock edge.
- R6: Pair codes 5, 6 and 7 read as 0, and a write with one of these codes changes no cell.
- R7: The bit port addresses bit `bit_idx` (0 = LSB) of the register at offset `bit_sel`. A bit write changes only that bit and leaves the other three bits of the nibble as stored.
- R8: The memory port reads and writes cell `mem_addr` (0 to 31) regardless of `bank_en` and `bank_sel`.
- R9: When several writes hit the same cell in one clock, the winner is decided in this order: pair first, then nibble, then bit, then memory. Writes to different cells in one clock all take effect.
- R10: Reads are combinational. During a write cycle they return the old value, and the new value shows after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_en | input | 1 | Bank-enable flag for named accesses |
| bank_sel | input | 2 | Bank-select value |
| nib_sel | input | 3 | Register offset for the nibble port |
| nib_we | input | 1 | Nibble write enable |
| nib_wdata | input | 4 | Nibble write data |
| nib_rdata | output | 4 | Nibble read data |
| bit_sel | input | 3 | Register offset for the bit port |
| bit_idx | input | 2 | Bit index inside the nibble |
| bit_we | input | 1 | Bit write enable |
| bit_wval | input | 1 | Bit write value |
| bit_rval | output | 1 | Bit read value |
| pair_sel | input | 3 | Pair code |
| pair_we | input | 1 | Pair write enable |
| pair_wdata | input | 8 | Pair write data |
| pair_rdata | output | 8 | Pair read data |
| mem_addr | input | 5 | Data-memory address |
| mem_we | input | 1 | Memory-port write enable |
| mem_wdata | input | 4 | Memory-port write data |
| mem_rdata | output | 4 | Memory-port read data |

## Verification
The bench builds the block with its default parameters: four banks of 4-bit cells. With these values a few hundred cycles are enough to write and read back every bank-select and enable combination, every named offset, every pair code including the three unused ones, and every memory address. Because there are only 32 cells, random cycles that drive all four ports at once often land on the same cell. This exercises the write-priority order far more often than directed cases alone would.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int REGS_PER_BANK = 8;
    localparam int OFF_W         = 3;

    // register offsets inside one bank
    localparam logic [OFF_W-1:0] OFF_A = 3'd0;
    localparam logic [OFF_W-1:0] OFF_E = 3'd1;
    localparam logic [OFF_W-1:0] OFF_L = 3'd2;
    localparam logic [OFF_W-1:0] OFF_H = 3'd3;
    localparam logic [OFF_W-1:0] OFF_X = 3'd4;
    localparam logic [OFF_W-1:0] OFF_W_REG = 3'd5;
    localparam logic [OFF_W-1:0] OFF_Z = 3'd6;
    localparam logic [OFF_W-1:0] OFF_Y = 3'd7;

    typedef enum logic [2:0] {
        PAIR_EA = 3'd0,
        PAIR_HL = 3'd1,
        PAIR_WX = 3'd2,
        PAIR_YZ = 3'd3,
        PAIR_WL = 3'd4
    } pair_code_e;

    typedef struct packed {
        logic             valid;
        logic [OFF_W-1:0] hi;
        logic [OFF_W-1:0] lo;
    } pair_map_t;

    function automatic pair_map_t decode_pair(input logic [2:0] code);
        pair_map_t m;
        m = '0;
        case (code)
            PAIR_EA: begin m.valid = 1'b1; m.hi = OFF_E;     m.lo = OFF_A; end
            PAIR_HL: begin m.valid = 1'b1; m.hi = OFF_H;     m.lo = OFF_L; end
            PAIR_WX: begin m.valid = 1'b1; m.hi = OFF_W_REG; m.lo = OFF_X; end
            PAIR_YZ: begin m.valid = 1'b1; m.hi = OFF_Y;     m.lo = OFF_Z; end
            PAIR_WL: begin m.valid = 1'b1; m.hi = OFF_W_REG; m.lo = OFF_L; end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wrf_bank_sel.sv
module wrf_bank_sel #(
    parameter int BANK_W = 2
) (
    input  logic              bank_en,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [BANK_W-1:0] bank_eff
);
    always_comb begin
        bank_eff = bank_en ? bank_sel : '0;
    end
endmodule

// File: rtl/wrf_pair_dec.sv
module wrf_pair_dec
    import wrf_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic [2:0]              pair_sel,
    input  logic [BANK_W-1:0]       bank,
    output logic                    valid,
    output logic [BANK_W+OFF_W-1:0] hi_cell,
    output logic [BANK_W+OFF_W-1:0] lo_cell
);
    pair_map_t map;

    always_comb begin
        map     = decode_pair(pair_sel);
        valid   = map.valid;
        hi_cell = {bank, map.hi};
        lo_cell = {bank, map.lo};
    end
endmodule

// File: rtl/wrf_cell_next.sv
module wrf_cell_next #(
    parameter int NIB_W = 4,
    parameter int BIT_W = $clog2(NIB_W)
) (
    input  logic [NIB_W-1:0] cur,
    input  logic             pair_hit,
    input  logic [NIB_W-1:0] pair_nib,
    input  logic             nib_hit,
    input  logic [NIB_W-1:0] nib_data,
    input  logic             bit_hit,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             bit_val,
    input  logic             mem_hit,
    input  logic [NIB_W-1:0] mem_data,
    output logic [NIB_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (pair_hit) begin
            nxt = pair_nib;
        end else if (nib_hit) begin
            nxt = nib_data;
        end else if (bit_hit) begin
            nxt          = cur;
            nxt[bit_idx] = bit_val;
        end else if (mem_hit) begin
            nxt = mem_data;
        end
    end
endmodule

// File: rtl/wreg_file.sv
module wreg_file
    import wrf_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int NIB_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bank_en,
    input  logic [$clog2(BANKS)-1:0]              bank_sel,
    input  logic [2:0]                            nib_sel,
    input  logic                                  nib_we,
    input  logic [NIB_W-1:0]                      nib_wdata,
    output logic [NIB_W-1:0]                      nib_rdata,
    input  logic [2:0]                            bit_sel,
    input  logic [$clog2(NIB_W)-1:0]              bit_idx,
    input  logic                                  bit_we,
    input  logic                                  bit_wval,
    output logic                                  bit_rval,
    input  logic [2:0]                            pair_sel,
    input  logic                                  pair_we,
    input  logic [2*NIB_W-1:0]                    pair_wdata,
    output logic [2*NIB_W-1:0]                    pair_rdata,
    input  logic [$clog2(BANKS)+OFF_W-1:0]        mem_addr,
    input  logic                                  mem_we,
    input  logic [NIB_W-1:0]                      mem_wdata,
    output logic [NIB_W-1:0]                      mem_rdata
);
    localparam int BANK_W = $clog2(BANKS);
    localparam int BIT_W  = $clog2(NIB_W);
    localparam int ADDR_W = BANK_W + OFF_W;
    localparam int NCELL  = BANKS * REGS_PER_BANK;

    typedef struct packed {
        logic [NCELL-1:0][NIB_W-1:0] cells;
    } state_t;

    state_t state_d, state_q;

    logic [BANK_W-1:0]       bank_eff;
    logic                    pair_valid;
    logic [ADDR_W-1:0]       pair_hi_cell, pair_lo_cell;
    logic [ADDR_W-1:0]       nib_cell, bit_cell;
    logic [NCELL-1:0][NIB_W-1:0] cell_nxt;

    wrf_bank_sel #(.BANK_W(BANK_W)) u_bank (
        .bank_en  (bank_en),
        .bank_sel (bank_sel),
        .bank_eff (bank_eff)
    );

    wrf_pair_dec #(.BANK_W(BANK_W)) u_pair (
        .pair_sel (pair_sel),
        .bank     (bank_eff),
        .valid    (pair_valid),
        .hi_cell  (pair_hi_cell),
        .lo_cell  (pair_lo_cell)
    );

    assign nib_cell = {bank_eff, nib_sel};
    assign bit_cell = {bank_eff, bit_sel};

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        localparam logic [ADDR_W-1:0] CA = ADDR_W'(c);
        logic             hit_hi, hit_lo, pair_hit;
        logic [NIB_W-1:0] pair_nib;

        assign hit_hi   = (pair_hi_cell == CA);
        assign hit_lo   = (pair_lo_cell == CA);
        assign pair_hit = pair_we && pair_valid && (hit_hi || hit_lo);
        assign pair_nib = hit_hi ? pair_wdata[2*NIB_W-1:NIB_W] : pair_wdata[NIB_W-1:0];

        wrf_cell_next #(.NIB_W(NIB_W), .BIT_W(BIT_W)) u_next (
            .cur      (state_q.cells[c]),
            .pair_hit (pair_hit),
            .pair_nib (pair_nib),
            .nib_hit  (nib_we && (nib_cell == CA)),
            .nib_data (nib_wdata),
            .bit_hit  (bit_we && (bit_cell == CA)),
            .bit_idx  (bit_idx),
            .bit_val  (bit_wval),
            .mem_hit  (mem_we && (mem_addr == CA)),
            .mem_data (mem_wdata),
            .nxt      (cell_nxt[c])
        );
    end

    // next-state process
    always_comb begin
        state_d       = state_q;
        state_d.cells = cell_nxt;
    end

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // read side
    logic [NIB_W-1:0] bit_nib;

    always_comb begin
        nib_rdata  = state_q.cells[nib_cell];
        bit_nib    = state_q.cells[bit_cell];
        bit_rval   = bit_nib[bit_idx];
        mem_rdata  = state_q.cells[mem_addr];
        pair_rdata = pair_valid ? {state_q.cells[pair_hi_cell], state_q.cells[pair_lo_cell]}
                                : '0;
    end

endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
    parameter int BANK_W = 2,
    parameter int NIB_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bank_en,
    input logic [BANK_W-1:0]         bank_sel,
    input logic [2:0]                nib_sel,
    input logic                      nib_we,
    input logic [NIB_W-1:0]          nib_wdata,
    input logic [NIB_W-1:0]          nib_rdata,
    input logic [2:0]                bit_sel,
    input logic [$clog2(NIB_W)-1:0]  bit_idx,
    input logic                      bit_we,
    input logic                      bit_wval,
    input logic                      bit_rval,
    input logic [2:0]                pair_sel,
    input logic                      pair_we,
    input logic [2*NIB_W-1:0]        pair_wdata,
    input logic [2*NIB_W-1:0]        pair_rdata,
    input logic [BANK_W+2:0]         mem_addr,
    input logic                      mem_we,
    input logic [NIB_W-1:0]          mem_wdata,
    input logic [NIB_W-1:0]          mem_rdata
);
    // R2
    bank0_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_en && mem_addr == {{BANK_W{1'b0}}, nib_sel}) |-> nib_rdata == mem_rdata);

    // R2
    bank_sel_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en && mem_addr == {bank_sel, nib_sel}) |-> nib_rdata == mem_rdata);

    // R6
    bad_pair_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sel > 3'd4) |-> pair_rdata == '0);

    // R5
    pair_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_we && pair_sel <= 3'd4) |=>
        (!$stable({pair_sel, bank_en, bank_sel}) || pair_rdata == $past(pair_wdata)));

    // R3
    nib_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_we && !pair_we) |=>
        (!$stable({nib_sel, bank_en, bank_sel}) || nib_rdata == $past(nib_wdata)));

    // R7
    bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !pair_we && !nib_we) |=>
        (!$stable({bit_sel, bit_idx, bank_en, bank_sel}) || bit_rval == $past(bit_wval)));

    // R8
    mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !pair_we && !nib_we && !bit_we) |=>
        (!$stable(mem_addr) || mem_rdata == $past(mem_wdata)));
endmodule

bind wreg_file wrf_chk #(.BANK_W(BANK_W), .NIB_W(NIB_W)) u_wrf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_en    (bank_en),
    .bank_sel   (bank_sel),
    .nib_sel    (nib_sel),
    .nib_we     (nib_we),
    .nib_wdata  (nib_wdata),
    .nib_rdata  (nib_rdata),
    .bit_sel    (bit_sel),
    .bit_idx    (bit_idx),
    .bit_we     (bit_we),
    .bit_wval   (bit_wval),
    .bit_rval   (bit_rval),
    .pair_sel   (pair_sel),
    .pair_we    (pair_we),
    .pair_wdata (pair_wdata),
    .pair_rdata (pair_rdata),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata)
);

// File: tb/test_wreg_file.sv
module test_wreg_file;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bank_en = 1'b0;
    logic [1:0] bank_sel = '0;
    logic [2:0] nib_sel = '0;
    logic       nib_we = 1'b0;
    logic [3:0] nib_wdata = '0;
    logic [3:0] nib_rdata;
    logic [2:0] bit_sel = '0;
    logic [1:0] bit_idx = '0;
    logic       bit_we = 1'b0;
    logic       bit_wval = 1'b0;
    logic       bit_rval;
    logic [2:0] pair_sel = '0;
    logic       pair_we = 1'b0;
    logic [7:0] pair_wdata = '0;
    logic [7:0] pair_rdata;
    logic [4:0] mem_addr = '0;
    logic       mem_we = 1'b0;
    logic [3:0] mem_wdata = '0;
    logic [3:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int model [32];

    always #2 clk = ~clk;

    wreg_file i_wreg_file (
        .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .bank_sel(bank_sel),
        .nib_sel(nib_sel), .nib_we(nib_we), .nib_wdata(nib_wdata), .nib_rdata(nib_rdata),
        .bit_sel(bit_sel), .bit_idx(bit_idx), .bit_we(bit_we), .bit_wval(bit_wval),
        .bit_rval(bit_rval), .pair_sel(pair_sel), .pair_we(pair_we),
        .pair_wdata(pair_wdata), .pair_rdata(pair_rdata), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int base();
        return bank_en ? 8 * int'(bank_sel) : 0;
    endfunction

    // pair table: high offset, low offset; -1 = unused code
    function automatic int pair_hi(input int code);
        case (code)
            0: return 1; 1: return 3; 2: return 5; 3: return 7; 4: return 5;
            default: return -1;
        endcase
    endfunction
    function automatic int pair_lo(input int code);
        case (code)
            0: return 0; 1: return 2; 2: return 4; 3: return 6; 4: return 2;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare all read outputs, clock once, then update the model
    task automatic cyc(input string tag);
        int old [32];
        int nw [32];
        int ph, pl, b;
        #1;
        b = base();
        check(tag, "nib_rdata", int'(nib_rdata), model[b + int'(nib_sel)]);
        check(tag, "bit_rval", int'(bit_rval), (model[b + int'(bit_sel)] >> bit_idx) & 1);
        check(tag, "mem_rdata", int'(mem_rdata), model[int'(mem_addr)]);
        ph = pair_hi(int'(pair_sel));
        pl = pair_lo(int'(pair_sel));
        check(tag, "pair_rdata", int'(pair_rdata),
              (ph < 0) ? 0 : (model[b + ph] * 16 + model[b + pl]));
        @(posedge clk);
        old = model;
        nw  = model;
        if (mem_we) nw[int'(mem_addr)] = int'(mem_wdata);
        if (bit_we) begin
            int v;
            v = old[b + int'(bit_sel)];
            if (bit_wval) v = v | (1 << bit_idx);
            else          v = v & ~(1 << bit_idx);
            nw[b + int'(bit_sel)] = v;
        end
        if (nib_we) nw[b + int'(nib_sel)] = int'(nib_wdata);
        if (pair_we && ph >= 0) begin
            nw[b + pl] = int'(pair_wdata) % 16;
            nw[b + ph] = int'(pair_wdata) / 16;
        end
        model = nw;
        @(negedge clk);
    endtask

    task automatic idle();
        nib_we = 0; bit_we = 0; pair_we = 0; mem_we = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        foreach (model[i]) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents
        for (int a = 0; a < 32; a++) begin
            mem_addr = 5'(a);
            cyc("R1");
        end

        // R3: every named offset in bank 0, then read back through memory
        for (int r = 0; r < 8; r++) begin
            nib_sel = 3'(r); nib_we = 1; nib_wdata = 4'(r + 3);
            cyc("R3");
        end
        idle();
        for (int r = 0; r < 8; r++) begin
            nib_sel = 3'(r); mem_addr = 5'(r);
            cyc("R3");
        end

        // R2: flag clear forces bank 0; flag set selects bank
        bank_en = 0; bank_sel = 2'd3; nib_sel = 3'd7; nib_we = 1; nib_wdata = 4'hC;
        cyc("R2");
        idle(); mem_addr = 5'd7; cyc("R2");
        mem_addr = 5'd31; cyc("R2");
        for (int bk = 0; bk < 4; bk++) begin
            bank_en = 1; bank_sel = 2'(bk); nib_sel = 3'd2; nib_we = 1; nib_wdata = 4'(9 + bk);
            cyc("R2");
            idle(); mem_addr = 5'(8 * bk + 2); cyc("R2");
        end

        // R10: reads show old value during a write cycle
        bank_en = 1; bank_sel = 2'd1; nib_sel = 3'd2; nib_we = 1; nib_wdata = 4'h1;
        cyc("R10");
        idle(); cyc("R10");

        // R4 / R5: pair write in each bank then read every code
        for (int bk = 0; bk < 4; bk++) begin
            bank_sel = 2'(bk);
            for (int pc = 0; pc < 5; pc++) begin
                pair_sel = 3'(pc); pair_we = 1; pair_wdata = 8'(16 * pc + 37 * bk + 5);
                cyc("R5");
                pair_we = 0;
                cyc("R5");
            end
            for (int pc = 0; pc < 5; pc++) begin
                pair_sel = 3'(pc);
                cyc("R4");
            end
        end

        // R6: unused pair codes read 0 and write nothing
        for (int pc = 5; pc < 8; pc++) begin
            pair_sel = 3'(pc); pair_we = 1; pair_wdata = 8'hFF;
            cyc("R6");
        end
        pair_we = 0;
        for (int a = 24; a < 32; a++) begin
            mem_addr = 5'(a); cyc("R6");
        end

        // R7: each bit of a nibble set and cleared
        bank_sel = 2'd2; bit_sel = 3'd6;
        for (int i = 0; i < 4; i++) begin
            bit_idx = 2'(i); bit_we = 1; bit_wval = ~model[16 + 6][i];
            cyc("R7");
            bit_we = 0; mem_addr = 5'd22; cyc("R7");
        end

        // R8: memory port ignores bank controls
        bank_en = 1; bank_sel = 2'd0;
        for (int a = 0; a < 32; a += 5) begin
            mem_addr = 5'(a); mem_we = 1; mem_wdata = 4'(a ^ 4'hA);
            cyc("R8");
        end
        mem_we = 0;
        for (int a = 0; a < 32; a += 5) begin
            mem_addr = 5'(a); cyc("R8");
        end

        // R9: directed collision, all four ports on cell 8+5 (W of bank 1)
        bank_en = 1; bank_sel = 2'd1;
        pair_sel = 3'd2; pair_we = 1; pair_wdata = 8'h3E;
        nib_sel = 3'd5; nib_we = 1; nib_wdata = 4'h7;
        bit_sel = 3'd5; bit_idx = 2'd0; bit_we = 1; bit_wval = 1'b0;
        mem_addr = 5'd13; mem_we = 1; mem_wdata = 4'h1;
        cyc("R9");
        idle(); cyc("R9");
        nib_we = 1; bit_we = 1; mem_we = 1; cyc("R9");
        idle(); cyc("R9");
        bit_we = 1; bit_idx = 2'd3; bit_wval = 1; mem_we = 1; cyc("R9");
        idle(); cyc("R9");

        // R9: random traffic on all ports
        for (int n = 0; n < 600; n++) begin
            bank_en    = 1'($urandom);
            bank_sel   = 2'($urandom);
            nib_sel    = 3'($urandom); nib_we  = 1'($urandom); nib_wdata  = 4'($urandom);
            bit_sel    = 3'($urandom); bit_idx = 2'($urandom); bit_we = 1'($urandom);
            bit_wval   = 1'($urandom);
            pair_sel   = 3'($urandom); pair_we = 1'($urandom); pair_wdata = 8'($urandom);
            mem_addr   = 5'($urandom); mem_we  = 1'($urandom); mem_wdata  = 4'($urandom);
            cyc("R9");
        end
        idle(); cyc("R9");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule